// File: doc/BRIEF.md
# Thread-Banked System-Control Register File

This block holds the system-control registers of a multithreaded core. Software addresses a register through a flat slot number formed from a register number and a select value. Each slot belongs to one of three storage kinds: a single copy for the whole core, one copy per virtual core, or one copy per hardware strand (thread context). Every access carries a strand id. For strand-kind slots, that id picks the copy directly. For virtual-core slots, the copy is chosen through the virtual-core field of the calling strand's binding register. Core-kind slots ignore the id.

Reset loads the multithreading start-up state. Strand 0 is active and the other strands are parked. Every write that lands starts one deferred re-evaluation of which strands may run. The re-evaluation is sequenced by a small state machine:

- IDLE: nothing is pending. On an effective write the machine takes the ARM transition to WAIT and loads the delay counter with `DELAY`.
- WAIT: the counter decrements once per cycle. Writes in this state do not re-arm it. When the counter reads zero, the FIRE transition moves the machine to EVAL.
- EVAL: the per-strand run mask is recomputed. The DONE transition then returns the machine to IDLE, which clears the pending flag.

Top module: `cprf_top`

## Requirements
- R1: The slot number is register number times 8 plus select. Slots 0..255 exist. For an index of 256 or more, reads return 0 and writes change nothing.
- R2: Every slot not listed in R3 or R4 is core-kind. It has one copy, and that copy is seen and written the same way whatever strand id is given.
- R3: Strand-kind slots are 17, 18, 19, 20, 21, 22, 23, 96, 136 and 184. The strand id selects the copy. A strand id of `NSTR` or more reads 0, and writes with such an id are dropped.
- R4: Virtual-core slots are 9 to 15, 49 to 53, and 121. The copy is selected by bits 3:0 of the binding slot 18 of the given strand. A binding value of `NVC` or more reads 0, and writes through it are dropped.
- R5: Reads are combinational. A write stores all 32 bits at the clock edge.
- R6: Reset clears every copy to zero except the following:
  - slots 128, 129 and 130 set bit 31;
  - slot 131 sets bit 2;
  - slot 2 holds bit 15 set, bits 13:10 = `NVC`-1 and bits 7:0 = `NSTR`-1;
  - slot 10 of virtual core 0 sets bit 1;
  - slot 18 of strand t holds t in bits 28:21;
  - slot 17 sets bit 15 for every strand, and bit 13 as well for strand 0.
- R7: An effective write while nothing is pending raises `upd_pending`. Exactly one evaluation then lands `DELAY`+2 edges after that write, and `upd_pending` drops on that same edge. Writes while pending schedule nothing more.
- R8: At evaluation, each strand t below both `NSTR` and (slot 2 bits 7:0)+1 gets `run_mask[t]` = NOT slot 20 bit 0 AND slot 17 bit 13, taken from its own copies. All other strands keep their bit.
- R9: `run_mask` resets to strand 0 only and changes at no edge other than an evaluation.
- R10: A write that lands nowhere, through R1, R3 or R4, does not raise `upd_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | 32 | Read slot number |
| rd_tid | input | 32 | Read strand id |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 32 | Write slot number |
| wr_tid | input | 32 | Write strand id |
| wr_data | input | 32 | Write data |
| run_mask | output | NSTR | Per-strand run permission |
| upd_pending | output | 1 | Re-evaluation scheduled and not yet done |

## Verification
The bench builds the block with four strands, two virtual cores and `DELAY` = 3. With only two virtual cores, a binding of 2 or 3 becomes reachable, so the dropped-access path of R4 can be exercised. Because the strand count reaches the maximum, every bank is exercised. A delay of three makes writes that arrive during WAIT observable. Lowering the strand-count field of slot 2 shows evaluation skipping strands above the count.

// File: rtl/cprf_pkg.sv
package cprf_pkg;

    localparam int SLOT_W    = 8;
    localparam int NUM_SLOTS = 1 << SLOT_W;

    // slots whose contents the block itself decodes
    localparam int SL_CORE_MT   = 2;
    localparam int SL_VC_CFG    = 10;
    localparam int SL_STR_STAT  = 17;
    localparam int SL_STR_BIND  = 18;
    localparam int SL_STR_HALT  = 20;
    localparam int SL_CFG_FIRST = 128;
    localparam int SL_CFG_LAST  = 131;

    // field positions
    localparam int BIND_VC_LO  = 0;
    localparam int BIND_ST_LO  = 21;
    localparam int STAT_ACT    = 13;
    localparam int STAT_DYN    = 15;
    localparam int HALT_BIT    = 0;
    localparam int MT_STR_LO   = 0;
    localparam int MT_VC_LO    = 10;
    localparam int MT_ALLOC    = 15;
    localparam int CFG_MORE    = 31;
    localparam int CFG_MT_HERE = 2;
    localparam int VC_MASTER   = 1;

    typedef enum logic [1:0] {
        KIND_CORE,
        KIND_VCORE,
        KIND_STRAND
    } bank_kind_e;

    function automatic bank_kind_e kind_of(input int unsigned slot);
        case (slot)
            9, 10, 11, 12, 13, 14, 15,
            49, 50, 51, 52, 53, 121:              return KIND_VCORE;
            17, 18, 19, 20, 21, 22, 23,
            96, 136, 184:                         return KIND_STRAND;
            default:                              return KIND_CORE;
        endcase
    endfunction

    function automatic logic [31:0] reset_value(input int bank, input int slot,
                                                input int nstr, input int nvc);
        logic [31:0] v;
        v = '0;
        if (slot >= SL_CFG_FIRST && slot < SL_CFG_LAST) v[CFG_MORE] = 1'b1;
        if (slot == SL_CFG_LAST) v[CFG_MT_HERE] = 1'b1;
        if (slot == SL_CORE_MT) begin
            v[MT_ALLOC]            = 1'b1;
            v[MT_VC_LO +: 4]       = 4'(nvc - 1);
            v[MT_STR_LO +: 8]      = 8'(nstr - 1);
        end
        if (slot == SL_VC_CFG && bank == 0) v[VC_MASTER] = 1'b1;
        if (slot == SL_STR_BIND) v[BIND_ST_LO +: 8] = 8'(bank);
        if (slot == SL_STR_STAT) begin
            v[STAT_DYN] = 1'b1;
            if (bank == 0) v[STAT_ACT] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/cprf_bank_sel.sv
module cprf_bank_sel
    import cprf_pkg::*;
#(
    parameter int NSTR = 4,
    parameter int NVC  = 2,
    parameter int NB   = 4,
    parameter int BW   = 2,
    parameter int TW   = 2
) (
    input  logic [31:0]            idx,
    input  logic [31:0]            tid,
    input  logic [NSTR-1:0][3:0]   bind_vc,
    output logic                   hit,
    output logic [BW-1:0]          bank,
    output logic [SLOT_W-1:0]      slot
);
    logic       slot_ok;
    logic       tid_ok;
    logic [3:0] vc;

    assign slot_ok = (idx < 32'(NUM_SLOTS));
    assign tid_ok  = (tid < 32'(NSTR));
    assign slot    = idx[SLOT_W-1:0];
    assign vc      = tid_ok ? bind_vc[tid[TW-1:0]] : 4'd0;

    always_comb begin
        hit  = 1'b0;
        bank = '0;
        if (slot_ok) begin
            unique case (kind_of({24'd0, slot}))
                KIND_CORE: begin
                    hit = 1'b1;
                end
                KIND_STRAND: begin
                    hit  = tid_ok;
                    bank = BW'(tid[TW-1:0]);
                end
                KIND_VCORE: begin
                    hit  = tid_ok && ({28'd0, vc} < 32'(NVC));
                    bank = BW'(vc);
                end
                default: hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cprf_store.sv
module cprf_store
    import cprf_pkg::*;
#(
    parameter int NSTR = 4,
    parameter int NVC  = 2,
    parameter int NB   = 4,
    parameter int BW   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_hit,
    input  logic [BW-1:0]          wr_bank,
    input  logic [SLOT_W-1:0]      wr_slot,
    input  logic [31:0]            wr_data,
    input  logic                   rd_hit,
    input  logic [BW-1:0]          rd_bank,
    input  logic [SLOT_W-1:0]      rd_slot,
    output logic [31:0]            rd_data,
    output logic [NSTR-1:0][3:0]   bind_vc,
    output logic [NSTR-1:0]        halt_bit,
    output logic [NSTR-1:0]        act_bit,
    output logic [7:0]             str_cnt
);
    logic [31:0] mem [NB][NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++)
                for (int s = 0; s < NUM_SLOTS; s++)
                    mem[b][s] <= reset_value(b, s, NSTR, NVC);
        end else if (wr_en && wr_hit) begin
            mem[wr_bank][wr_slot] <= wr_data;
        end
    end

    assign rd_data = rd_hit ? mem[rd_bank][rd_slot] : 32'd0;
    assign str_cnt = mem[0][SL_CORE_MT][MT_STR_LO +: 8];

    for (genvar g = 0; g < NSTR; g++) begin : g_str
        assign bind_vc[g]  = mem[g][SL_STR_BIND][BIND_VC_LO +: 4];
        assign halt_bit[g] = mem[g][SL_STR_HALT][HALT_BIT];
        assign act_bit[g]  = mem[g][SL_STR_STAT][STAT_ACT];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit) |=> mem[$past(wr_bank)][$past(wr_slot)] == $past(wr_data)); // R5
endmodule

// File: rtl/cprf_run_eval.sv
module cprf_run_eval #(
    parameter int NSTR  = 4,
    parameter int DELAY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [NSTR-1:0]  halt_bit,
    input  logic [NSTR-1:0]  act_bit,
    input  logic [7:0]       str_cnt,
    output logic [NSTR-1:0]  run_mask,
    output logic             pending
);
    localparam int CW = (DELAY > 0) ? $clog2(DELAY + 1) : 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_EVAL
    } ev_state_e;

    ev_state_e st, st_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            ST_IDLE: if (trig) begin
                st_nxt  = ST_WAIT;
                cnt_nxt = CW'(DELAY);
            end
            ST_WAIT: if (cnt == '0) st_nxt = ST_EVAL;
                     else           cnt_nxt = cnt - 1'b1;
            ST_EVAL: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_mask <= NSTR'(1);
        end else if (st == ST_EVAL) begin
            for (int t = 0; t < NSTR; t++)
                if (32'(t) <= {24'd0, str_cnt})
                    run_mask[t] <= !halt_bit[t] && act_bit[t];
        end
    end

    assign pending = (st != ST_IDLE);

    AST_WAIT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && cnt != '0) |=> (st == ST_WAIT && cnt == $past(cnt) - 1'b1)); // R7
    AST_EVAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EVAL) |=> (st == ST_IDLE)); // R7
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_EVAL) |=> $stable(run_mask)); // R9
endmodule

// File: rtl/cprf_top.sv
module cprf_top
    import cprf_pkg::*;
#(
    parameter int NSTR  = 4,
    parameter int NVC   = 2,
    parameter int DELAY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      rd_idx,
    input  logic [31:0]      rd_tid,
    output logic [31:0]      rd_data,
    input  logic             wr_en,
    input  logic [31:0]      wr_idx,
    input  logic [31:0]      wr_tid,
    input  logic [31:0]      wr_data,
    output logic [NSTR-1:0]  run_mask,
    output logic             upd_pending
);
    localparam int NB = (NSTR > NVC) ? NSTR : NVC;
    localparam int BW = (NB > 1) ? $clog2(NB) : 1;
    localparam int TW = (NSTR > 1) ? $clog2(NSTR) : 1;

    logic [NSTR-1:0][3:0] bind_vc;
    logic [NSTR-1:0]      halt_bit, act_bit;
    logic [7:0]           str_cnt;
    logic                 rd_hit, wr_hit;
    logic [BW-1:0]        rd_bank, wr_bank;
    logic [SLOT_W-1:0]    rd_slot, wr_slot;

    cprf_bank_sel #(.NSTR(NSTR), .NVC(NVC), .NB(NB), .BW(BW), .TW(TW)) u_rsel (
        .idx(rd_idx), .tid(rd_tid), .bind_vc(bind_vc),
        .hit(rd_hit), .bank(rd_bank), .slot(rd_slot));

    cprf_bank_sel #(.NSTR(NSTR), .NVC(NVC), .NB(NB), .BW(BW), .TW(TW)) u_wsel (
        .idx(wr_idx), .tid(wr_tid), .bind_vc(bind_vc),
        .hit(wr_hit), .bank(wr_bank), .slot(wr_slot));

    cprf_store #(.NSTR(NSTR), .NVC(NVC), .NB(NB), .BW(BW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_hit(wr_hit), .wr_bank(wr_bank), .wr_slot(wr_slot),
        .wr_data(wr_data),
        .rd_hit(rd_hit), .rd_bank(rd_bank), .rd_slot(rd_slot), .rd_data(rd_data),
        .bind_vc(bind_vc), .halt_bit(halt_bit), .act_bit(act_bit), .str_cnt(str_cnt));

    cprf_run_eval #(.NSTR(NSTR), .DELAY(DELAY)) u_eval (
        .clk(clk), .rst_n(rst_n), .trig(wr_en && wr_hit),
        .halt_bit(halt_bit), .act_bit(act_bit), .str_cnt(str_cnt),
        .run_mask(run_mask), .pending(upd_pending));

    AST_HIT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && !upd_pending) |=> upd_pending); // R7
    AST_MISS_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit && !upd_pending) |=> !upd_pending); // R10
endmodule

// File: tb/sim_cprf_top.sv
`timescale 1ns/1ps
module sim_cprf_top;
    localparam int NSTR  = 4;
    localparam int NVC   = 2;
    localparam int DELAY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rd_idx = '0, rd_tid = '0, wr_idx = '0, wr_tid = '0, wr_data = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rd_data;
    logic [NSTR-1:0] run_mask;
    logic        upd_pending;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // behavioural reference
    bit [31:0] mm [0:3][0:255];
    bit [NSTR-1:0] m_run;
    bit m_pend;
    int due;
    int edge_no;

    cprf_top #(.NSTR(NSTR), .NVC(NVC), .DELAY(DELAY)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_tid(rd_tid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tid(wr_tid), .wr_data(wr_data),
        .run_mask(run_mask), .upd_pending(upd_pending));

    always #5 clk = ~clk;

    function automatic int kind(input int unsigned s);
        if ((s >= 9 && s <= 15) || (s >= 49 && s <= 53) || s == 121) return 1;
        if ((s >= 17 && s <= 23) || s == 96 || s == 136 || s == 184) return 2;
        return 0;
    endfunction

    function automatic int pick(input int unsigned idx, input int unsigned tid);
        int unsigned vc;
        if (idx > 255) return -1;
        if (kind(idx) == 0) return 0;
        if (tid >= NSTR) return -1;
        if (kind(idx) == 2) return int'(tid);
        vc = mm[tid][18] & 32'hF;
        if (vc >= NVC) return -1;
        return int'(vc);
    endfunction

    task automatic model_reset();
        foreach (mm[b, s]) mm[b][s] = 0;
        mm[0][128] = 32'h8000_0000;
        mm[0][129] = 32'h8000_0000;
        mm[0][130] = 32'h8000_0000;
        mm[0][131] = 32'h0000_0004;
        mm[0][2]   = 32'h8000 | ((NVC - 1) << 10) | (NSTR - 1);
        mm[0][10]  = 32'h2;
        for (int t = 0; t < NSTR; t++) begin
            mm[t][18] = t << 21;
            mm[t][17] = (t == 0) ? 32'hA000 : 32'h8000;
        end
        m_run = 1;
        m_pend = 0;
        due = -1;
        edge_no = 0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit en, input int unsigned wi, input int unsigned wt,
                        input logic [31:0] wd, input int unsigned ri, input int unsigned rt,
                        input string rtag);
        int b;
        bit was_pend;
        @(negedge clk);
        chk("R8/R9 run_mask", 32'(run_mask), 32'(m_run));
        chk("R7 upd_pending", 32'(upd_pending), 32'(m_pend));
        wr_en = en; wr_idx = wi; wr_tid = wt; wr_data = wd;
        rd_idx = ri; rd_tid = rt;
        #1;
        b = pick(ri, rt);
        chk(rtag, rd_data, (b < 0) ? 32'd0 : mm[b][ri]);
        // effect of the coming edge
        edge_no++;
        was_pend = m_pend;
        if (m_pend && edge_no == due) begin
            for (int t = 0; t < NSTR; t++)
                if (t <= int'(mm[0][2] & 32'hFF))
                    m_run[t] = !mm[t][20][0] && mm[t][17][13];
            m_pend = 0;
        end
        b = pick(wi, wt);
        if (en && b >= 0) begin
            if (!was_pend) begin
                m_pend = 1;
                due = edge_no + DELAY + 2;
            end
            mm[b][wi] = wd;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "R5 idle read");
    endtask

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;

        // R6: reset image, every slot, every strand id (4 = out of range, R3)
        for (int t = 0; t <= NSTR; t++)
            for (int s = 0; s < 260; s++)
                step(0, 0, 0, 0, s, t, (s > 255) ? "R1 out-of-range read" : "R6 reset image");

        // R2: core slot written through strand 2, read through strand 0
        step(1, 128, 2, 32'h0000_00A5, 0, 0, "R5");
        step(0, 0, 0, 0, 128, 0, "R2 shared copy");
        step(0, 0, 0, 0, 128, 3, "R2 shared copy");
        idle(8);

        // R3: per-strand copies, second write lands while pending
        step(1, 21, 1, 32'h11, 0, 0, "R5");
        step(1, 21, 2, 32'h22, 21, 1, "R3 strand copy");
        step(0, 0, 0, 0, 21, 1, "R3 strand 1");
        step(0, 0, 0, 0, 21, 2, "R3 strand 2");
        step(0, 0, 0, 0, 21, 0, "R3 strand 0 untouched");
        idle(8);

        // R10 and R3: dropped writes (bad strand id, bad index) never arm
        step(1, 21, 5, 32'hDEAD, 21, 5, "R3 bad strand read");
        step(1, 300, 0, 32'hDEAD, 300, 0, "R1 bad index read");
        step(0, 0, 0, 0, 44, 0, "R1 alias slot untouched");
        @(negedge clk); chk("R10 no pending after dropped writes", 32'(upd_pending), 0);
        idle(2);

        // R4: virtual-core bank chosen through binding
        step(1, 18, 3, 32'h1, 0, 0, "R5");
        step(1, 121, 3, 32'hBEEF, 121, 3, "R4 before write");
        step(0, 0, 0, 0, 121, 3, "R4 vcore 1 copy");
        step(0, 0, 0, 0, 121, 0, "R4 vcore 0 untouched");
        step(0, 0, 0, 0, 10, 3, "R4 vcore 1 cfg");
        step(0, 0, 0, 0, 10, 0, "R4 vcore 0 cfg");
        idle(8);
        step(1, 18, 3, 32'h3, 0, 0, "R5");
        idle(8);
        step(1, 121, 3, 32'h1234, 121, 3, "R4 invalid binding read");
        @(negedge clk); chk("R10 invalid binding write", 32'(upd_pending), 0);
        step(1, 18, 3, 32'h1, 0, 0, "R5");
        step(0, 0, 0, 0, 121, 3, "R4 dropped write left value");
        idle(8);

        // R8: activate strand 1, then halt strand 0
        step(1, 17, 1, 32'h2000, 0, 0, "R5");
        idle(8);
        chk("R8 strand 1 runs", 32'(run_mask), 32'h3);
        step(1, 20, 0, 32'h1, 20, 0, "R5");
        step(1, 17, 1, 32'h0, 0, 0, "R7 write while pending");
        idle(8);
        chk("R8 both writes seen by single evaluation", 32'(run_mask), 32'h0);

        // R8: strand count lowered to one, strand 2 made runnable but skipped
        step(1, 2, 0, 32'h0, 0, 0, "R5");
        idle(8);
        step(1, 17, 2, 32'h2000, 0, 0, "R5");
        step(1, 20, 0, 32'h0, 0, 0, "R7");
        idle(8);
        chk("R8 strand 2 outside count keeps bit", 32'(run_mask), 32'h1);

        // mixed traffic
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            int unsigned sl;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            case (lf[2:0])
                3'd0: sl = 2;   3'd1: sl = 17;  3'd2: sl = 18;  3'd3: sl = 20;
                3'd4: sl = 121; 3'd5: sl = 96;  3'd6: sl = 131; default: sl = 12;
            endcase
            step(lf[5], sl, lf[8:6] % 5, (sl == 18) ? (lf & 32'h3) : lf,
                 sl, lf[11:9] % 5, "R5 mixed traffic");
        end
        idle(10);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule